// File: doc/BRIEF.md
# Timer Time Base with Double-Buffered Reload

This block is the counting core of a general-purpose timer. A programmable divider turns the input clock into counting ticks. A 16-bit counter runs up or down between zero and a limit value. A repetition stage decides how many wraps pass before an update event is issued. Software programs the block through a small word-addressed register port with a combinational read path.

The limit value is held twice. Software writes a staged copy, and the counter compares against an active copy. When buffering is turned on, the staged value reaches the active copy only at an update event. When buffering is off, it reaches the active copy at once. The divider works the same way: its staged value is taken into use only at an update event. An update event can come from a counted wrap, from a one-shot software command or from a pulse on an external trigger input. Software can hold off all update events with a control bit. Every update event sets a sticky flag, and that flag can drive an interrupt line.

Registers (word address on `addr`): 0 control, 1 event command, 2 status, 3 counter, 4 divider, 5 limit, 6 repetition count. Control bits: bit 0 run, bit 1 count down, bit 2 hold updates, bit 3 buffered limit, bit 4 interrupt enable.

Top module: `upd_timebase`

## Requirements
- R1: Writes to the control (address 0, bits 4:0), counter (address 3), divider (address 4), limit (address 5) and repetition (address 6) registers read back on `rdata`. The limit address returns the staged value. The status register (address 2) returns the flag in bit 0. All registers read 0 after reset.
- R2: The divider value is applied only at an update event. After that, the counter moves once every (divider + 1) clock cycles in which the internal enable is high. The internal enable follows the run bit with one cycle of delay, so a counter at rest after a run write with divider 0 first changes on the second rising edge after the write edge.
- R3: When counting up, a tick with the counter equal to the active limit sets the counter to 0, and this is an overflow.
- R4: When counting down, a tick with the counter at 0 sets it to the active limit, and this is an underflow.
- R5: With buffering off (control bit 3 = 0), a limit write changes the active limit at the same edge.
- R6: With buffering on, a limit write changes only the staged copy. An update event copies the staged value into the active limit. If a limit write and an update event fall in the same cycle, the newly written value is the one copied.
- R7: With repetition value N, only every (N+1)-th overflow or underflow issues an update event. Each update event reloads the repetition counter from the register.
- R8: Writing 1 to bit 0 of address 1 issues an update event at once. It resets the divider and sets the counter to 0 when counting up, or to the new active limit when counting down. A pulse on `trig_in` issues an update event that reloads the divider and repetition stages but leaves the counter value unchanged.
- R9: While control bit 2 is set, no update event is produced from any source. The flag stays clear, the software command leaves the counter alone, and the counter still wraps.
- R10: Each update event sets the status flag, which stays set until a write to address 2 with bit 0 = 0. If an update event and a clearing write fall in the same cycle, the update event wins. `irq` is the flag ANDed with control bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| trig_in | input | 1 | External trigger, forces an update event |
| upd_evt | output | 1 | One-cycle pulse on each update event |
| irq | output | 1 | Update interrupt request |

## Verification
Two pairs of actions can collide in a single cycle. In the first, a buffered limit write lands on the same edge as a trigger pulse. The bench drives both together and then runs the counter past the old limit, so only the new value lets the count reach 5 without wrapping. In the second, a flag-clearing status write coincides with a trigger pulse, and the status must still read 1 after that edge. The stimulus table sweeps the divider, limit, repetition value and direction, and checks each final count and flag against values worked out by hand.

// File: rtl/utb_pkg.sv
package utb_pkg;
    parameter int unsigned CNT_W = 16;
    parameter int unsigned REP_W = 8;
    parameter int unsigned ADR_W = 3;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REP_W-1:0] rep_t;

    typedef struct packed {
        logic irq_en;
        logic buffered;
        logic hold_upd;
        logic down;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef enum logic [ADR_W-1:0] {
        A_CTRL  = 3'd0,
        A_EVT   = 3'd1,
        A_STAT  = 3'd2,
        A_COUNT = 3'd3,
        A_DIV   = 3'd4,
        A_LIMIT = 3'd5,
        A_REPS  = 3'd6
    } reg_addr_e;

    function automatic logic at_turn(input logic down, input cnt_t cnt, input cnt_t lim);
        return down ? (cnt == '0) : (cnt == lim);
    endfunction

    function automatic cnt_t step(input logic down, input logic turn, input cnt_t cnt, input cnt_t lim);
        if (turn) return down ? lim : '0;
        return down ? cnt - 1'b1 : cnt + 1'b1;
    endfunction
endpackage

// File: rtl/utb_prescaler.sv
module utb_prescaler
    import utb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  cnt_t div_in,
    output logic tick
);
    cnt_t div_sh;
    cnt_t pcnt;

    assign tick = en && (pcnt == div_sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt   <= '0;
            div_sh <= '0;
        end else if (clr) begin
            pcnt   <= '0;
            div_sh <= div_in;
        end else if (en) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

    assert_psc_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(pcnt));
    assert_psc_restart_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0));
endmodule

// File: rtl/utb_reload.sv
module utb_reload
    import utb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic buffered,
    input  cnt_t wdata,
    input  logic upd,
    output cnt_t staged,
    output cnt_t active,
    output cnt_t active_nx
);
    cnt_t staged_nx;

    always_comb begin
        staged_nx = wr ? wdata : staged;
        if (wr && !buffered) active_nx = wdata;
        else if (upd)        active_nx = staged_nx;
        else                 active_nx = active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            active <= '0;
        end else begin
            staged <= staged_nx;
            active <= active_nx;
        end
    end

    assert_buffer_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (buffered && !upd) |=> $stable(active));
    assert_direct_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && !buffered) |=> (active == staged));
endmodule

// File: rtl/utb_repeat.sv
module utb_repeat
    import utb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic force_ld,
    input  rep_t rep_in,
    output logic fire
);
    rep_t rcnt;

    assign fire = wrap && (rcnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                  rcnt <= '0;
        else if (force_ld || fire) rcnt <= rep_in;
        else if (wrap)            rcnt <= rcnt - 1'b1;
    end

    assert_rep_countdown_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !force_ld && rcnt != '0) |=> (rcnt == $past(rcnt) - 1'b1));
endmodule

// File: rtl/upd_timebase.sv
module upd_timebase
    import utb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             trig_in,
    output logic             upd_evt,
    output logic             irq
);
    ctrl_t ctrl;
    cnt_t  cnt, div_reg, lim_staged, lim_active, lim_nx;
    rep_t  rep_reg;
    logic  cnt_en, flag, tick, wrap, fire, sw_ug, upd, sw_rst;
    logic  wr_ctrl, wr_stat, wr_cnt, wr_div, wr_lim, wr_rep;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_cnt  = wr_en && (addr == A_COUNT);
    assign wr_div  = wr_en && (addr == A_DIV);
    assign wr_lim  = wr_en && (addr == A_LIMIT);
    assign wr_rep  = wr_en && (addr == A_REPS);
    assign sw_ug   = wr_en && (addr == A_EVT) && wdata[0];

    assign wrap    = tick && at_turn(ctrl.down, cnt, lim_active);
    assign upd     = !ctrl.hold_upd && (fire || sw_ug || trig_in);
    assign sw_rst  = upd && sw_ug;
    assign upd_evt = upd;
    assign irq     = flag && ctrl.irq_en;

    utb_prescaler u_psc (
        .clk(clk), .rst(rst), .en(cnt_en), .clr(upd),
        .div_in(div_reg), .tick(tick)
    );

    utb_reload u_lim (
        .clk(clk), .rst(rst), .wr(wr_lim), .buffered(ctrl.buffered),
        .wdata(wdata), .upd(upd), .staged(lim_staged),
        .active(lim_active), .active_nx(lim_nx)
    );

    utb_repeat u_rep (
        .clk(clk), .rst(rst), .wrap(wrap),
        .force_ld(!ctrl.hold_upd && (sw_ug || trig_in)),
        .rep_in(rep_reg), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            cnt_en  <= 1'b0;
            div_reg <= '0;
            rep_reg <= '0;
            flag    <= 1'b0;
            cnt     <= '0;
        end else begin
            cnt_en <= ctrl.run;
            if (wr_ctrl) ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_div)  div_reg <= wdata;
            if (wr_rep)  rep_reg <= wdata[REP_W-1:0];
            if (upd)                      flag <= 1'b1;
            else if (wr_stat && !wdata[0]) flag <= 1'b0;
            if (wr_cnt)      cnt <= wdata;
            else if (sw_rst) cnt <= ctrl.down ? lim_nx : '0;
            else if (tick)   cnt <= step(ctrl.down, wrap, cnt, lim_active);
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = CNT_W'(ctrl);
            A_STAT:  rdata = CNT_W'(flag);
            A_COUNT: rdata = cnt;
            A_DIV:   rdata = div_reg;
            A_LIMIT: rdata = lim_staged;
            A_REPS:  rdata = CNT_W'(rep_reg);
            default: rdata = '0;
        endcase
    end

    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl.down && cnt == lim_active && !wr_cnt && !sw_rst) |=> (cnt == '0));
    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl.down && cnt == '0 && !wr_cnt && !sw_rst) |=> (cnt == $past(lim_active)));
    assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold_upd |-> !upd_evt);
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_stat && !wdata[0])) |=> flag);
    assert_sw_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_rst && !ctrl.down) |=> (cnt == '0));
    assert_enable_lag_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_en && !wr_cnt && !sw_rst) |=> $stable(cnt));
endmodule

// File: tb/upd_timebase_test.sv
module upd_timebase_test;
    localparam int CLK_NS = 10;
    localparam int NV = 8;
    // columns: divider, limit, reps, down, enabled cycles, expected count, expected flag
    localparam int VEC [NV][7] = '{
        '{0,   9, 0, 0,  5,  5, 0},
        '{0,   4, 0, 0,  7,  2, 1},
        '{2,   3, 0, 0, 13,  0, 1},
        '{0,   3, 1, 0,  6,  2, 0},
        '{0,   3, 1, 0,  8,  0, 1},
        '{0,   5, 0, 1,  4,  1, 0},
        '{1,   5, 0, 1, 14,  4, 1},
        '{3, 100, 0, 0, 40, 10, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        trig_in = 1'b0;
    logic        upd_evt, irq;
    int total = 0;
    int bad = 0;
    logic [15:0] v;

    upd_timebase uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .trig_in(trig_in), .upd_evt(upd_evt), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input bit trg);
        wr_en = 1'b1; addr = 3'(a); wdata = 16'(d); trig_in = trg;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; trig_in = 1'b0; addr = 3'd0; wdata = 16'd0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        addr = 3'(a);
        #1;
        d = rdata;
    endtask

    task automatic run_for(input int ctl, input int n);
        wr(0, ctl | 1, 1'b0);
        repeat (n - 1) @(negedge clk);
        wr(0, ctl, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R1 and R10
        rd(3, v); check("R1 count after reset", v, 0);
        rd(0, v); check("R1 control after reset", v, 0);
        rd(5, v); check("R1 limit after reset", v, 0);
        rd(2, v); check("R10 flag after reset", v, 0);
        check("R10 irq after reset", irq, 0);

        // readback, R1
        wr(4, 16'h1234, 1'b0); rd(4, v); check("R1 divider readback", v, 16'h1234);
        wr(6, 7, 1'b0);        rd(6, v); check("R1 reps readback", v, 7);
        wr(3, 16'hBEEF, 1'b0); rd(3, v); check("R1 counter readback", v, 16'hBEEF);
        wr(0, 16'h1A, 1'b0);   rd(0, v); check("R1 control readback", v, 16'h1A);

        // table of stimulus: R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            int dn;
            dn = VEC[i][3] ? 2 : 0;
            wr(0, dn, 1'b0);
            wr(4, VEC[i][0], 1'b0);
            wr(5, VEC[i][1], 1'b0);
            wr(6, VEC[i][2], 1'b0);
            wr(1, 1, 1'b0);
            wr(2, 0, 1'b0);
            run_for(dn, VEC[i][4]);
            rd(3, v); check($sformatf("R2/R3/R4/R5 count vector %0d", i), v, VEC[i][5]);
            rd(2, v); check($sformatf("R7 flag vector %0d", i), v, VEC[i][6]);
        end

        // buffered limit, R6 and R8
        wr(0, 0, 1'b0); wr(4, 0, 1'b0); wr(6, 0, 1'b0); wr(5, 9, 1'b0);
        wr(1, 1, 1'b0); wr(2, 0, 1'b0);
        wr(0, 8, 1'b0); wr(5, 2, 1'b0);
        rd(5, v); check("R6 staged limit readback", v, 2);
        run_for(8, 5);
        rd(3, v); check("R6 active limit not yet replaced", v, 5);
        wr(1, 1, 1'b0);
        rd(3, v); check("R8 software update clears up counter", v, 0);
        wr(2, 0, 1'b0);
        run_for(8, 4);
        rd(3, v); check("R6 new limit after update", v, 1);
        rd(2, v); check("R6 wrap at new limit flags update", v, 1);

        // same-cycle buffered write and trigger, R6 R8 R10
        wr(2, 0, 1'b0); wr(3, 3, 1'b0);
        wr(5, 6, 1'b1);
        rd(2, v); check("R8 trigger sets flag", v, 1);
        rd(3, v); check("R8 trigger keeps counter", v, 3);
        wr(2, 0, 1'b1);
        rd(2, v); check("R10 set wins over clear", v, 1);
        wr(2, 0, 1'b0);
        rd(2, v); check("R10 clear by writing 0", v, 0);
        wr(3, 0, 1'b0);
        run_for(8, 5);
        rd(3, v); check("R6 same-cycle write reached active limit", v, 5);
        wr(7, 0, 1'b1);
        wr(0, 16'h18, 1'b0);
        check("R10 irq follows flag and enable", irq, 1);

        // update hold, R9
        wr(0, 4, 1'b0); wr(2, 0, 1'b0);
        wr(7, 0, 1'b1);
        rd(2, v); check("R9 trigger ignored while held", v, 0);
        wr(3, 3, 1'b0); wr(1, 1, 1'b0);
        rd(3, v); check("R9 software update ignored while held", v, 3);
        wr(3, 5, 1'b0);
        run_for(4, 3);
        rd(3, v); check("R9 counter still wraps while held", v, 1);
        rd(2, v); check("R9 wrap raises no flag while held", v, 0);

        // enable latency, R2
        wr(0, 0, 1'b0); wr(1, 1, 1'b0);
        wr(0, 1, 1'b0);
        rd(3, v); check("R2 no move at write edge", v, 0);
        @(negedge clk); rd(3, v); check("R2 no move at first edge after", v, 0);
        @(negedge clk); rd(3, v); check("R2 moves at second edge after", v, 1);
        wr(0, 0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule